// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This peripheral is a bus-attached watchdog. Software programs it once after power-on reset with a reload count, an enable and a few mode bits. From then on the block counts down, either once per clock or once per prescaler period. Software keeps it from expiring by writing a fixed pair of 16-bit keys, in order, to a service halfword. A stray value written to the service halfword does not reload the counter.

When the count reaches zero the block stops counting and acts. Depending on a mode bit it sends a one-clock reset request to the system reset generator, or it raises a level interrupt that stays high until the next valid service. A sticky status bit records that a watchdog reset was requested. Only power-on reset clears it, or software writing 1 to it. An optional freeze mode halts the whole time base while an external debug-halt input is high.

All configuration is written once. The first full-word write to the control word after power-on reset locks every field, including the enable. Reading the control word back shows the settings that are actually in force, so software can see that a later enable was refused.

Top module: `keyed_wdog`

## Requirements
- R1: After power-on reset the control word, the count word and the status word all read 0, and both `rstReq` and `irq` are low.
- R2: Register map by word address:
  - 0x4 is control: bits 31:16 hold the reload count, bit 3 freeze, bit 2 enable, bit 1 action select, bit 0 prescale.
  - 0x8 is the live count in bits 15:0. Writes to it have no effect.
  - 0x10 is status, with the watchdog-reset flag in bit 0.
  - Unmapped words read 0.
- R3: Only the first control write after power-on reset takes effect, and it must have all four byte strobes set. Every later control write is ignored, including one that tries to set the enable, and the read-back still shows the locked value.
- R4: A control write with enable set loads the counter with the reload count. While enabled, the counter then decrements by one per clock when prescale is 0, and it stays at 0 once it reaches 0.
- R5: With prescale set, the counter decrements once every PRE_DIV clocks. The default is 65536, and 2048 is the other intended setting.
- R6: The service halfword sits at byte offset 0xE, which is bits 31:16 of word 0xC with strobes 3 and 2. Writing 0x556C and then 0xAA39 reloads the counter and restarts the prescaler. Any other value in between cancels the sequence. Repeated 0x556C writes keep it armed.
- R7: With select = 1, `rstReq` is high for exactly one clock. That clock starts at the edge after the edge at which the count became 0, and `irq` stays low.
- R8: With select = 0, `irq` rises at that same edge and stays high until a valid key pair reloads the counter. `rstReq` stays low.
- R9: The status flag is set when a reset request is issued. Writing 1 to status bit 0 clears it, and a set in the same cycle wins over a clear.
- R10: While freeze is set and `dbgHalt` is high, both the counter and the prescaler hold their values.
- R11: A valid reload completed in the same clock in which the expiry would fire wins. No reset request is issued and the status flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| busAddr | input | ADDR_W | Byte address of the access |
| busWe | input | 1 | Write enable |
| busBe | input | 4 | Byte strobes |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| dbgHalt | input | 1 | Debug halt, honoured only when freeze is set |
| rstReq | output | 1 | One-clock system reset request |
| irq | output | 1 | Level interrupt request |

## Verification
Two events can fall on the same clock: the expiry firing and the second key completing a reload. The bench provokes this by counting clocks from a known reload so that the 0xAA39 write lands exactly on the edge where the reset pulse would otherwise start. It then checks that `rstReq` stays low, that the status flag stays clear, and that the count restarts from the reload value. A second overlap is between the prescaler and the debug halt. Halt is released at a known edge, and the first decrement must come a full prescaler period later, which shows that the prescaler did not run during the halt.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;
  localparam int CNT_W = 16;
  localparam logic [15:0] KEY_ARM  = 16'h556C;
  localparam logic [15:0] KEY_FIRE = 16'hAA39;
  localparam int IDX_CTRL = 1;
  localparam int IDX_CNT  = 2;
  localparam int IDX_SVC  = 3;
  localparam int IDX_STAT = 4;

  typedef struct packed {
    logic [CNT_W-1:0] reloadVal;
    logic             frz;
    logic             en;
    logic             selRst;
    logic             pre;
  } cfg_t;

  typedef struct packed {
    logic             reload;
    logic             start;
    logic             stickyClr;
    logic [CNT_W-1:0] loadVal;
  } stb_t;
endpackage

// File: rtl/keyed_wdog_ctrl.sv
module keyed_wdog_ctrl
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output cfg_t              cfg,
  output logic              locked,
  output stb_t              stb
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wIdx;
  logic ctrlWr, svcWr, statWr, lockWr, armed;
  logic [15:0] svcVal;

  assign wIdx   = busAddr[ADDR_W-1:2];
  assign ctrlWr = busWe && (wIdx == IDX_W'(IDX_CTRL)) && (busBe == 4'hF);
  assign svcWr  = busWe && (wIdx == IDX_W'(IDX_SVC)) && (busBe[3:2] == 2'b11);
  assign statWr = busWe && (wIdx == IDX_W'(IDX_STAT)) && busBe[0];
  assign lockWr = ctrlWr && !locked;
  assign svcVal = busWdata[31:16];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg    <= '0;
      locked <= 1'b0;
      armed  <= 1'b0;
    end else begin
      if (lockWr) begin
        cfg <= '{reloadVal: busWdata[31:16], frz: busWdata[3], en: busWdata[2],
                 selRst: busWdata[1], pre: busWdata[0]};
        locked <= 1'b1;
      end
      if (svcWr) armed <= (svcVal == KEY_ARM);
    end
  end

  always_comb begin
    stb.reload    = svcWr && armed && (svcVal == KEY_FIRE) && cfg.en;
    stb.start     = lockWr && busWdata[2];
    stb.stickyClr = statWr && busWdata[0];
    stb.loadVal   = stb.start ? busWdata[31:16] : cfg.reloadVal;
  end
endmodule

// File: rtl/keyed_wdog_dp.sv
module keyed_wdog_dp
  import keyed_wdog_pkg::*;
#(
  parameter int PRE_DIV = 65536
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfg_t             cfg,
  input  stb_t             stb,
  input  logic             dbgHalt,
  output logic [CNT_W-1:0] cnt,
  output logic             rstReq,
  output logic             irq,
  output logic             sticky
);
  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] preCnt;
  logic fired, halt, tick, fireNow;

  assign halt    = cfg.frz && dbgHalt;
  assign tick    = !cfg.pre || (preCnt == PRE_LAST);
  assign fireNow = cfg.en && !halt && (cnt == '0) && !fired && !stb.reload && !stb.start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      preCnt <= '0;
      fired  <= 1'b0;
      rstReq <= 1'b0;
      irq    <= 1'b0;
      sticky <= 1'b0;
    end else begin
      rstReq <= 1'b0;
      if (stb.reload || stb.start) begin
        cnt    <= stb.loadVal;
        preCnt <= '0;
        fired  <= 1'b0;
        irq    <= 1'b0;
      end else if (cfg.en && !halt) begin
        if (cnt == '0) begin
          if (!fired) begin
            fired  <= 1'b1;
            rstReq <= cfg.selRst;
            irq    <= !cfg.selRst;
          end
        end else if (tick) begin
          cnt    <= cnt - 1'b1;
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
      if (fireNow && cfg.selRst) sticky <= 1'b1;
      else if (stb.stickyClr)    sticky <= 1'b0;
    end
  end
endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
  import keyed_wdog_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int PRE_DIV = 65536
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [3:0]        busBe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              dbgHalt,
  output logic              rstReq,
  output logic              irq
);
  localparam int IDX_W = ADDR_W - 2;

  cfg_t cfg;
  stb_t stb;
  logic locked, sticky;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] rIdx;

  keyed_wdog_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busBe(busBe),
    .busWdata(busWdata), .cfg(cfg), .locked(locked), .stb(stb)
  );

  keyed_wdog_dp #(.PRE_DIV(PRE_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .dbgHalt(dbgHalt),
    .cnt(cnt), .rstReq(rstReq), .irq(irq), .sticky(sticky)
  );

  assign rIdx = busAddr[ADDR_W-1:2];

  always_comb begin
    busRdata = '0;
    if (rIdx == IDX_W'(IDX_CTRL))
      busRdata = {cfg.reloadVal, 12'd0, cfg.frz, cfg.en, cfg.selRst, cfg.pre};
    else if (rIdx == IDX_W'(IDX_CNT))
      busRdata = {{(32-CNT_W){1'b0}}, cnt};
    else if (rIdx == IDX_W'(IDX_STAT))
      busRdata = {31'd0, sticky};
  end
endmodule

// File: rtl/keyed_wdog_chk.sv
module keyed_wdog_chk
  import keyed_wdog_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             rstReq,
  input logic             irq,
  input logic             dbgHalt,
  input logic             locked,
  input cfg_t             cfg,
  input stb_t             stb,
  input logic [CNT_W-1:0] cnt
);
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rstN) rstReq |=> !rstReq); // R7
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rstN) !(rstReq && irq)); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN) (irq && !stb.reload) |=> irq); // R8
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rstN) locked |=> $stable(cfg)); // R3
  AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.reload && !stb.start) |=> (cnt <= $past(cnt))); // R4
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.frz && dbgHalt && !stb.reload) |=> $stable(cnt)); // R10
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (!rstN) stb.reload |=> !rstReq); // R11
endmodule

bind keyed_wdog keyed_wdog_chk u_chk (
  .clk(clk), .rstN(rstN), .rstReq(rstReq), .irq(irq), .dbgHalt(dbgHalt),
  .locked(locked), .cfg(cfg), .stb(stb), .cnt(cnt)
);

// File: tb/test_keyed_wdog.sv
module test_keyed_wdog;
  localparam int PRE = 4;

  logic clk = 1'b0, rstN = 1'b0, busWe = 1'b0, dbgHalt = 1'b0;
  logic [4:0] busAddr = '0;
  logic [3:0] busBe = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic rstReq, irq;

  typedef struct {
    int kind;
    logic [31:0] exp;
    string tag;
  } item_t;

  item_t q[$];
  event sampleEv;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  keyed_wdog #(.ADDR_W(5), .PRE_DIV(PRE)) i_keyed_wdog (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busBe(busBe),
    .busWdata(busWdata), .busRdata(busRdata), .dbgHalt(dbgHalt),
    .rstReq(rstReq), .irq(irq)
  );

  // monitor: pop the expected item and compare against what the design shows now
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      @(sampleEv);
      it = q.pop_front();
      case (it.kind)
        0: act = busRdata;
        1: act = {31'd0, rstReq};
        default: act = {31'd0, irq};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%0h expected=%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    -> sampleEv;
    #1;
  endtask

  task automatic chkRd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a;
    #2;
    push(0, exp, tag);
  endtask

  task automatic chkPin(input int kind, input logic exp, input string tag);
    @(negedge clk);
    #2;
    push(kind, {31'd0, exp}, tag);
  endtask

  task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWe = 1'b1; busBe = be; busWdata = d;
    @(posedge clk);
    #1;
    busWe = 1'b0; busBe = '0;
  endtask

  task automatic skip(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic por();
    @(negedge clk);
    rstN = 1'b0;
    skip(3);
    rstN = 1'b1;
  endtask

  task automatic keys();
    wr(5'hC, 4'hC, 32'h556C_0000);
    wr(5'hC, 4'hC, 32'hAA39_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // phase 1: reset mode, no prescale
    por();
    chkRd(5'h4, 32'h0, "R1 control");
    chkRd(5'h8, 32'h0, "R1 count");
    chkRd(5'h10, 32'h0, "R1 status");
    chkPin(1, 1'b0, "R1 rstReq");
    chkPin(2, 1'b0, "R1 irq");
    wr(5'h8, 4'hF, 32'h0000_1234);
    chkRd(5'h8, 32'h0, "R2 count write ignored");
    wr(5'h4, 4'hF, 32'h0014_0006);
    chkRd(5'h4, 32'h0014_0006, "R2 control fields");
    chkRd(5'h8, 32'd19, "R4 first decrement");
    wr(5'h4, 4'hF, 32'h00FF_0000);
    chkRd(5'h4, 32'h0014_0006, "R3 second write ignored");
    keys();
    chkRd(5'h8, 32'd20, "R6 reload");
    chkRd(5'h8, 32'd19, "R4 count per clock");
    skip(18);
    chkPin(1, 1'b0, "R7 not before");
    chkPin(1, 1'b1, "R7 pulse");
    chkPin(1, 1'b0, "R7 one clock");
    chkRd(5'h8, 32'd0, "R4 stays at zero");
    chkRd(5'h10, 32'd1, "R9 sticky set");
    chkPin(2, 1'b0, "R7 no irq");
    wr(5'h10, 4'h1, 32'h1);
    chkRd(5'h10, 32'd0, "R9 write one clears");
    wr(5'hC, 4'hC, 32'h556C_0000);
    wr(5'hC, 4'hC, 32'h1234_0000);
    wr(5'hC, 4'hC, 32'hAA39_0000);
    chkRd(5'h8, 32'd0, "R6 broken sequence");
    wr(5'hC, 4'hC, 32'h556C_0000);
    keys();
    chkRd(5'h8, 32'd20, "R6 repeated arm key");
    skip(18);
    keys();
    chkPin(1, 1'b0, "R11 reload beats expiry");
    chkRd(5'h8, 32'd19, "R11 count restarted");
    chkRd(5'h10, 32'd0, "R11 sticky clear");

    // phase 2: interrupt mode, prescale, freeze
    por();
    chkRd(5'h10, 32'd0, "R1 status after por");
    wr(5'h4, 4'hF, 32'h0003_000D);
    chkRd(5'h4, 32'h0003_000D, "R2 control fields");
    keys();
    chkRd(5'h8, 32'd3, "R5 reload");
    skip(2);
    chkRd(5'h8, 32'd3, "R5 held within period");
    chkRd(5'h8, 32'd2, "R5 decrement after period");
    skip(7);
    chkPin(2, 1'b0, "R8 not before");
    chkPin(2, 1'b1, "R8 irq rises");
    skip(5);
    chkPin(2, 1'b1, "R8 irq level");
    chkPin(1, 1'b0, "R8 no reset");
    keys();
    chkPin(2, 1'b0, "R8 cleared by service");
    chkRd(5'h8, 32'd3, "R8 reloaded");
    @(negedge clk);
    dbgHalt = 1'b1;
    keys();
    skip(10);
    chkRd(5'h8, 32'd3, "R10 frozen");
    @(negedge clk);
    dbgHalt = 1'b0;
    skip(2);
    chkRd(5'h8, 32'd3, "R10 prescaler held");
    chkRd(5'h8, 32'd2, "R10 resumes");

    // phase 3: refused enable
    por();
    wr(5'h4, 4'hF, 32'h0005_0000);
    wr(5'h4, 4'hF, 32'h0005_0006);
    chkRd(5'h4, 32'h0005_0000, "R3 enable refused");
    skip(10);
    chkRd(5'h8, 32'd0, "R3 stays disabled");
    chkPin(1, 1'b0, "R3 no reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule